// File: doc/BRIEF.md
# Identification ROM Command Engine

This block is the command layer of a single-wire identification slave whose only content is a fixed 64-bit ROM code. The code is made of an 8-bit family code, a 48-bit serial number and an 8-bit check byte, and it is set by a parameter. The block sits above a bit-level slot engine. That engine supplies a strobe for each detected bus reset (sent after its presence pulse), a strobe with the value of each bit the master writes, and an acknowledge each time it has driven a bit the command layer asked to send.

After every bus reset the engine gathers an 8-bit command, least significant bit first. Two opcodes start a read ROM, which streams all 64 ROM bits in order. One opcode starts the search arbitration. In a search, each ROM bit is offered as the bit, then as its complement, and is followed by the master's chosen direction. A slave whose bit disagrees with that direction leaves the search. Match ROM, skip ROM and any other code make the engine fall silent until the next bus reset. Because the bus is a wired-AND, several slaves may send at once, and the master sees the AND of what they drive.

Top module: `idrom_cmd_engine`

## Requirements
- R1: After the synchronous reset `rst`, `tx_req_o` and `done_o` are 0, and received bits are ignored until the first `bus_reset_i` strobe.
- R2: After a `bus_reset_i` strobe, the next 8 `rx_valid_i` strobes form the command byte. The first bit received is bit 0 of the byte.
- R3: Command 8'h33 and command 8'h0F each start a read ROM. The engine raises `tx_req_o` for 64 bits, and the k-th bit sent is `ROM_CODE[k]`. The family code is `ROM_CODE[7:0]`, the serial number is `ROM_CODE[55:8]` and the check byte is `ROM_CODE[63:56]`.
- R4: Commands 8'h55 and 8'hCC, and any other code except 8'h33, 8'h0F and 8'hF0, leave `tx_req_o` and `done_o` at 0 until the next `bus_reset_i`.
- R5: Command 8'hF0 starts a search. For bit k, the engine first sends `ROM_CODE[k]`, then sends its complement, and then waits for one `rx_valid_i` direction bit.
- R6: In a search, a direction bit equal to `ROM_CODE[k]` moves the engine on to bit k+1. A direction bit that differs makes the engine silent until the next `bus_reset_i`.
- R7: `done_o` pulses high for exactly one cycle on two events: the acknowledge of the 64th bit of a read ROM, and a matching 64th direction bit of a search.
- R8: A `bus_reset_i` strobe in any state returns the engine to command reception. It takes priority over a `tx_ack_i` or `rx_valid_i` in the same cycle, and in that case no `done_o` pulse is produced.
- R9: While `tx_req_o` is high, `tx_req_o` and `tx_bit_o` do not change until `tx_ack_i` or `bus_reset_i` arrives.
- R10: An `rx_valid_i` strobe that arrives while the engine is sending bits does not change the bit sequence it sends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_reset_i | input | 1 | One-cycle strobe: the bit layer has detected a bus reset and sent its presence pulse |
| rx_valid_i | input | 1 | One-cycle strobe: the master has written a bit |
| rx_bit_i | input | 1 | Value of the written bit, valid with `rx_valid_i` |
| tx_ack_i | input | 1 | One-cycle strobe: the requested bit has been driven in a read slot |
| tx_req_o | output | 1 | A bit is waiting to be sent in the next read slot |
| tx_bit_o | output | 1 | Value of the bit to send |
| done_o | output | 1 | One-cycle pulse when a read ROM or a search has completed all 64 bits |

## Verification
The two functions that can meet in one cycle are the completion of a 64-bit transfer and a bus reset that aborts it. The bench provokes this by driving `bus_reset_i` in the same cycle as the acknowledge of the 64th bit of a read ROM. It then judges that `done_o` stays low and `tx_req_o` drops. It also checks that the next command byte is accepted from its first bit, which shows that command reception was restarted cleanly rather than left partway through.

// File: rtl/idrom_pkg.sv
package idrom_pkg;
  typedef enum logic [2:0] {
    ST_SILENT,
    ST_CMD,
    ST_READ,
    ST_S_BIT,
    ST_S_CMP,
    ST_S_DIR
  } eng_state_t;

  localparam logic [7:0] OP_READ_A = 8'h33;
  localparam logic [7:0] OP_READ_B = 8'h0F;
  localparam logic [7:0] OP_SEARCH = 8'hF0;
endpackage

// File: rtl/idrom_cmd_rx.sv
module idrom_cmd_rx #(
  parameter int CMD_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             en,
  input  logic             rx_valid,
  input  logic             rx_bit,
  output logic             cmd_done,
  output logic [CMD_W-1:0] cmd_byte
);
  localparam int CNT_W = $clog2(CMD_W);

  logic [CMD_W-1:0] shreg;
  logic [CNT_W-1:0] cnt;

  // Bits arrive LSB first, so each new bit enters at the top.
  assign cmd_byte = {rx_bit, shreg[CMD_W-1:1]};
  assign cmd_done = en && rx_valid && (cnt == CNT_W'(CMD_W-1));

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      shreg <= '0;
      cnt   <= '0;
    end else if (en && rx_valid) begin
      shreg <= cmd_byte;
      cnt   <= cnt + 1'b1;
    end
  end

  // R2: a bus reset restarts the bit count of the command byte
  a_r2_count_restart: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0));
endmodule

// File: rtl/idrom_bit_ptr.sv
module idrom_bit_ptr #(
  parameter int                  ROM_BITS = 64,
  parameter logic [ROM_BITS-1:0] ROM_CODE = '0,
  localparam int                 IDX_W    = $clog2(ROM_BITS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr,
  input  logic             adv,
  output logic [IDX_W-1:0] idx,
  output logic             last,
  output logic             rom_bit,
  output logic             nxt_bit
);
  logic [IDX_W-1:0] idx_n;

  assign last = (idx == IDX_W'(ROM_BITS-1));

  always_comb begin
    idx_n = idx;
    if (clr)       idx_n = '0;
    else if (adv)  idx_n = last ? '0 : idx + 1'b1;
  end

  assign rom_bit = ROM_CODE[idx];
  assign nxt_bit = ROM_CODE[idx_n];

  always_ff @(posedge clk) begin
    if (rst) idx <= '0;
    else     idx <= idx_n;
  end

  // R3: each accepted bit steps to the next ROM position
  a_r3_ptr_step: assert property (@(posedge clk) disable iff (rst)
    (adv && !clr && !last) |=> (idx == IDX_W'($past(idx) + 1'b1)));
endmodule

// File: rtl/idrom_ctrl_fsm.sv
module idrom_ctrl_fsm
  import idrom_pkg::*;
#(
  parameter int CMD_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_reset,
  input  logic             cmd_done,
  input  logic [CMD_W-1:0] cmd_byte,
  input  logic             tx_ack,
  input  logic             rx_valid,
  input  logic             rx_bit,
  input  logic             rom_bit,
  input  logic             nxt_bit,
  input  logic             last,
  output logic             cmd_en,
  output logic             ptr_adv,
  output logic             tx_req_o,
  output logic             tx_bit_o,
  output logic             done_o
);
  eng_state_t st, st_n;
  logic       fin;

  always_comb begin
    st_n    = st;
    ptr_adv = 1'b0;
    fin     = 1'b0;
    if (bus_reset) begin
      st_n = ST_CMD;
    end else begin
      unique case (st)
        ST_CMD: if (cmd_done) begin
          if (cmd_byte == OP_READ_A || cmd_byte == OP_READ_B) st_n = ST_READ;
          else if (cmd_byte == OP_SEARCH)                     st_n = ST_S_BIT;
          else                                                st_n = ST_SILENT;
        end
        ST_READ: if (tx_ack) begin
          ptr_adv = 1'b1;
          if (last) begin
            fin  = 1'b1;
            st_n = ST_SILENT;
          end
        end
        ST_S_BIT: if (tx_ack) st_n = ST_S_CMP;
        ST_S_CMP: if (tx_ack) st_n = ST_S_DIR;
        ST_S_DIR: if (rx_valid) begin
          if (rx_bit != rom_bit) begin
            st_n = ST_SILENT;
          end else begin
            ptr_adv = 1'b1;
            if (last) begin
              fin  = 1'b1;
              st_n = ST_SILENT;
            end else begin
              st_n = ST_S_BIT;
            end
          end
        end
        default: st_n = ST_SILENT;
      endcase
    end
  end

  assign cmd_en = (st == ST_CMD);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_SILENT;
      tx_req_o <= 1'b0;
      tx_bit_o <= 1'b0;
      done_o   <= 1'b0;
    end else begin
      st       <= st_n;
      tx_req_o <= (st_n == ST_READ) || (st_n == ST_S_BIT) || (st_n == ST_S_CMP);
      tx_bit_o <= (st_n == ST_S_CMP) ? ~nxt_bit : nxt_bit;
      done_o   <= fin;
    end
  end

  // R4: a silent engine stays silent until a bus reset
  a_r4_silent_hold: assert property (@(posedge clk) disable iff (rst)
    (st == ST_SILENT && !bus_reset) |=> (st == ST_SILENT && !tx_req_o));

  // R9: a requested bit stays put until acknowledged
  a_r9_tx_hold: assert property (@(posedge clk) disable iff (rst)
    (tx_req_o && !tx_ack && !bus_reset) |=> (tx_req_o && $stable(tx_bit_o)));

  // R8: a bus reset always lands in command reception with no output
  a_r8_abort: assert property (@(posedge clk) disable iff (rst)
    bus_reset |=> (st == ST_CMD && !tx_req_o && !done_o));

  // R7: completion is a single-cycle pulse
  a_r7_done_pulse: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  // R5: the second slot of a search step carries the complement
  a_r5_complement: assert property (@(posedge clk) disable iff (rst)
    (st == ST_S_CMP) |-> (tx_bit_o != rom_bit));
endmodule

// File: rtl/idrom_cmd_engine.sv
module idrom_cmd_engine #(
  parameter int             ROM_BITS = 64,
  parameter int             CMD_W    = 8,
  parameter logic [63:0]    ROM_CODE = 64'hA200_0012_3456_7801
) (
  input  logic clk,
  input  logic rst,
  input  logic bus_reset_i,
  input  logic rx_valid_i,
  input  logic rx_bit_i,
  input  logic tx_ack_i,
  output logic tx_req_o,
  output logic tx_bit_o,
  output logic done_o
);
  localparam int IDX_W = $clog2(ROM_BITS);

  logic             cmd_en, cmd_done, ptr_adv, last, rom_bit, nxt_bit;
  logic [CMD_W-1:0] cmd_byte;
  logic [IDX_W-1:0] idx;

  idrom_cmd_rx #(.CMD_W(CMD_W)) u_cmd_rx (
    .clk      (clk),
    .rst      (rst),
    .clr      (bus_reset_i),
    .en       (cmd_en),
    .rx_valid (rx_valid_i),
    .rx_bit   (rx_bit_i),
    .cmd_done (cmd_done),
    .cmd_byte (cmd_byte)
  );

  idrom_bit_ptr #(
    .ROM_BITS (ROM_BITS),
    .ROM_CODE (ROM_CODE[ROM_BITS-1:0])
  ) u_bit_ptr (
    .clk     (clk),
    .rst     (rst),
    .clr     (bus_reset_i),
    .adv     (ptr_adv),
    .idx     (idx),
    .last    (last),
    .rom_bit (rom_bit),
    .nxt_bit (nxt_bit)
  );

  idrom_ctrl_fsm #(.CMD_W(CMD_W)) u_fsm (
    .clk       (clk),
    .rst       (rst),
    .bus_reset (bus_reset_i),
    .cmd_done  (cmd_done),
    .cmd_byte  (cmd_byte),
    .tx_ack    (tx_ack_i),
    .rx_valid  (rx_valid_i),
    .rx_bit    (rx_bit_i),
    .rom_bit   (rom_bit),
    .nxt_bit   (nxt_bit),
    .last      (last),
    .cmd_en    (cmd_en),
    .ptr_adv   (ptr_adv),
    .tx_req_o  (tx_req_o),
    .tx_bit_o  (tx_bit_o),
    .done_o    (done_o)
  );

  // R1: no request may be pending while the pointer is idle after reset
  a_r1_idle_reset: assert property (@(posedge clk)
    rst |=> (!tx_req_o && !done_o && idx == '0));
endmodule

// File: tb/idrom_cmd_engine_tb.sv
module idrom_cmd_engine_tb;
  localparam logic [63:0] ROM = 64'hA200_0012_3456_7801;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bus_reset_i = 1'b0, rx_valid_i = 1'b0, rx_bit_i = 1'b0, tx_ack_i = 1'b0;
  logic tx_req_o, tx_bit_o, done_o;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  idrom_cmd_engine #(.ROM_CODE(ROM)) u_dut (
    .clk(clk), .rst(rst), .bus_reset_i(bus_reset_i), .rx_valid_i(rx_valid_i),
    .rx_bit_i(rx_bit_i), .tx_ack_i(tx_ack_i), .tx_req_o(tx_req_o),
    .tx_bit_o(tx_bit_o), .done_o(done_o)
  );

  // {command, kind}: kind 0 = silent, 1 = read ROM, 2 = search
  localparam logic [9:0] VEC [6] = '{
    {8'h33, 2'd1}, {8'h0F, 2'd1}, {8'h55, 2'd0},
    {8'hCC, 2'd0}, {8'hF0, 2'd2}, {8'hA5, 2'd0}
  };

  task automatic chk(input logic ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_reset();
    bus_reset_i = 1'b1;
    @(negedge clk);
    bus_reset_i = 1'b0;
  endtask

  task automatic send_bit(input logic b, output logic d);
    rx_valid_i = 1'b1;
    rx_bit_i   = b;
    @(negedge clk);
    rx_valid_i = 1'b0;
    d = done_o;
  endtask

  task automatic send_cmd(input logic [7:0] c);
    logic d;
    for (int i = 0; i < 8; i++) send_bit(c[i], d);
  endtask

  task automatic take_bit(input string tag, output logic b, output logic d);
    int t = 0;
    while (!tx_req_o && t < 50) begin
      @(negedge clk);
      t++;
    end
    if (t >= 50) chk(1'b0, tag, 0, 1);
    b = tx_bit_o;
    tx_ack_i = 1'b1;
    @(negedge clk);
    tx_ack_i = 1'b0;
    d = done_o;
  endtask

  task automatic quiet(input int n, input string tag);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (tx_req_o || done_o) bad++;
    end
    chk(bad == 0, tag, bad, 0);
  endtask

  task automatic do_read(input string tag);
    logic b, d;
    int errs = 0, early = 0;
    for (int i = 0; i < 64; i++) begin
      take_bit(tag, b, d);
      if (b != ROM[i]) errs++;
      if (i < 63 && d) early++;
      if (i == 63) chk(d == 1'b1, {tag, " R7 done on 64th bit"}, int'(d), 1);
    end
    chk(errs == 0, {tag, " R3 bit sequence"}, errs, 0);
    chk(early == 0, {tag, " R7 no early done"}, early, 0);
    quiet(10, {tag, " R7 silent after read"});
  endtask

  task automatic do_search(input string tag);
    logic b, c, d;
    int errs = 0, early = 0;
    for (int i = 0; i < 64; i++) begin
      take_bit(tag, b, d);
      take_bit(tag, c, d);
      if (b != ROM[i] || c != ~ROM[i]) errs++;
      send_bit(ROM[i], d);
      if (i < 63 && d) early++;
      if (i == 63) chk(d == 1'b1, {tag, " R7 search done"}, int'(d), 1);
    end
    chk(errs == 0, {tag, " R5 bit/complement pairs"}, errs, 0);
    chk(early == 0, {tag, " R6 no early done"}, early, 0);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin : main
    logic b, c, d;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state and bits ignored before any bus reset
    chk(tx_req_o == 1'b0, "R1 tx_req after reset", int'(tx_req_o), 0);
    chk(done_o == 1'b0, "R1 done after reset", int'(done_o), 0);
    send_cmd(8'h33);
    quiet(10, "R1 command ignored before bus reset");

    // R2/R3/R4/R5: table of commands
    foreach (VEC[k]) begin
      pulse_reset();
      send_cmd(VEC[k][9:2]);
      case (VEC[k][1:0])
        2'd1: do_read($sformatf("R2 R3 cmd %02h", VEC[k][9:2]));
        2'd2: do_search($sformatf("R5 cmd %02h", VEC[k][9:2]));
        default: quiet(20, $sformatf("R4 cmd %02h silent", VEC[k][9:2]));
      endcase
    end

    // R6: mismatch at bit 5 drops out
    pulse_reset();
    send_cmd(8'hF0);
    for (int i = 0; i < 5; i++) begin
      take_bit("R6", b, d);
      take_bit("R6", c, d);
      send_bit(ROM[i], d);
    end
    take_bit("R6", b, d);
    chk(b == ROM[5], "R6 bit 5 value", int'(b), int'(ROM[5]));
    take_bit("R6", c, d);
    chk(c == ~ROM[5], "R6 bit 5 complement", int'(c), int'(~ROM[5]));
    send_bit(~ROM[5], d);
    quiet(20, "R6 silent after mismatch");

    // R8: abort in the middle of a read, then a fresh read
    pulse_reset();
    send_cmd(8'h0F);
    for (int i = 0; i < 10; i++) take_bit("R8", b, d);
    pulse_reset();
    chk(tx_req_o == 1'b0, "R8 tx_req after abort", int'(tx_req_o), 0);
    send_cmd(8'h33);
    take_bit("R8", b, d);
    chk(b == ROM[0], "R8 first bit after abort", int'(b), int'(ROM[0]));

    // R10: a written bit during a read does not disturb it
    pulse_reset();
    send_cmd(8'h33);
    for (int i = 0; i < 3; i++) take_bit("R10", b, d);
    send_bit(1'b1, d);
    send_bit(1'b0, d);
    take_bit("R10", b, d);
    chk(b == ROM[3], "R10 bit 3 after stray write", int'(b), int'(ROM[3]));

    // R8/R7: bus reset coincident with the final acknowledge
    pulse_reset();
    send_cmd(8'h33);
    for (int i = 0; i < 63; i++) take_bit("R8", b, d);
    bus_reset_i = 1'b1;
    tx_ack_i    = 1'b1;
    @(negedge clk);
    bus_reset_i = 1'b0;
    tx_ack_i    = 1'b0;
    chk(done_o == 1'b0, "R8 R7 no done when reset wins", int'(done_o), 0);
    chk(tx_req_o == 1'b0, "R8 tx_req dropped", int'(tx_req_o), 0);
    send_cmd(8'h0F);
    take_bit("R8", b, d);
    chk(b == ROM[0], "R8 command accepted after coincidence", int'(b), int'(ROM[0]));

    // R9: request is held while no acknowledge comes
    pulse_reset();
    send_cmd(8'hF0);
    repeat (5) @(negedge clk);
    chk(tx_req_o == 1'b1 && tx_bit_o == ROM[0], "R9 request held",
        int'({tx_req_o, tx_bit_o}), int'({1'b1, ROM[0]}));

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule